// File: doc/BRIEF.md
# DMA Remapping Translation Unit

This block stands between device-initiated DMA and system memory. Each incoming DMA request carries the 16-bit requester identity of the issuing function and a guest physical address. The unit resolves the requester to a translation domain through a small programmable context table. It then looks up the page in a fully associative translation cache tagged by domain and 4 KiB page number, and returns a host physical address or a fault.

When the cache has no matching entry, the unit does not walk page tables. It raises a miss request naming the domain and guest page, then holds the DMA until software supplies the host page and its permissions through the fill port. The translation is then retried from the cache. Software can also drop every cached entry of one domain in a single cycle.

Only one DMA is in flight at a time. The request port is back-pressured from acceptance until the answer is produced.

Top module: `dmar_unit`

## Requirements
- R1: The requester identity is 16 bits, with bus in [15:8], device in [7:3] and function in [2:0]. A context slot written through the programming port with its enable bit set maps that exact identity to a domain number, and the mapping is used from the next request on. Entries that share a domain share cached translations.
- R2: If a request matches no enabled context slot, the response carries rsp_fault=1. At the same edge the unit pulses fault_valid with fault_code=1, the requester identity and the guest address. No miss request is raised. Clearing a slot's enable bit makes its requester fault this way, even when its pages are cached.
- R3: A request accepted at a clock edge that hits the cache with the needed permission produces rsp_valid=1 and rsp_fault=0 at the following edge. The host address is the cached host page number joined with guest address bits [11:0]. rsp_valid lasts one cycle.
- R4: A request that misses raises miss_valid at the edge after acceptance, carrying the domain and guest page number (guest address bits above bit 11). miss_valid stays high with stable contents until a fill arrives.
- R5: A fill presented while miss_valid is high installs the entry, and the response appears at the second edge after the fill edge, checked against the new entry.
- R6: Each entry holds a read and a write permission bit. A write needs the write bit and a read needs the read bit. A violation gives rsp_fault=1 and a fault pulse with fault_code=2.
- R7: req_ready is low from the acceptance edge until the response edge. A request held at the port during that time is not accepted.
- R8: The cache has 16 entries, filled in round-robin order. After 16 further fills the oldest entry is replaced, and its page misses again.
- R9: An invalidate command removes, in one cycle, every entry of the named domain. Entries of other domains keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Unit can accept a request |
| req_rid | input | 16 | Requester identity (bus, device, function) |
| req_write | input | 1 | 1 for a DMA write, 0 for a read |
| req_gpa | input | 48 | Guest physical address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault, no memory access |
| rsp_hpa | output | 48 | Translated host physical address |
| ctx_wr | input | 1 | Context slot write strobe |
| ctx_slot | input | 3 | Context slot index |
| ctx_rid | input | 16 | Requester identity stored in the slot |
| ctx_dom | input | 8 | Domain number stored in the slot |
| ctx_enable | input | 1 | Slot enable bit |
| miss_valid | output | 1 | Software translation request pending |
| miss_dom | output | 8 | Domain of the pending miss |
| miss_vpn | output | 36 | Guest page number of the pending miss |
| fill_valid | input | 1 | Software fill strobe |
| fill_ppn | input | 36 | Host page number for the pending miss |
| fill_read | input | 1 | Read permission of the fill |
| fill_write | input | 1 | Write permission of the fill |
| inv_valid | input | 1 | Invalidate-by-domain strobe |
| inv_dom | input | 8 | Domain to invalidate |
| fault_valid | output | 1 | One-cycle fault record strobe |
| fault_code | output | 2 | 1 = no context, 2 = permission |
| fault_rid | output | 16 | Requester identity of the faulting DMA |
| fault_gpa | output | 48 | Guest address of the faulting DMA |

## Verification
A cache hit or a context fault is answered two edges after the accepting edge, counting that edge as the first. A miss is announced one edge after acceptance, and the response follows two edges after the fill edge. The bench drives inputs on falling edges and samples exactly in the cycle where each result is due. It also checks that nothing is present one cycle earlier: no response during the lookup cycle or the cycle after a fill. During a stall of several cycles it checks that miss_valid holds and that req_ready stays low.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_WAIT = 2'd2
   } dmar_state_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_NOCTX = 2'd1,
      FLT_PERM  = 2'd2
   } dmar_fault_e;

   localparam int RID_W = 16;
endpackage

// File: rtl/dmar_ctx_table.sv
module dmar_ctx_table #(
   parameter int SLOTS = 8,
   parameter int RID_W = 16,
   parameter int DOM_W = 8,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [RID_W-1:0] wr_rid,
   input  logic [DOM_W-1:0] wr_dom,
   input  logic             wr_enable,
   input  logic [RID_W-1:0] lk_rid,
   output logic             lk_hit,
   output logic [DOM_W-1:0] lk_dom
);
   logic             en_q  [SLOTS];
   logic [RID_W-1:0] rid_q [SLOTS];
   logic [DOM_W-1:0] dom_q [SLOTS];
   logic [SLOTS-1:0] match;

   if (SLOTS < 1) begin : g_bad_slots
      $error("dmar_ctx_table: SLOTS must be at least 1");
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_match
      assign match[i] = en_q[i] && (rid_q[i] == lk_rid);
   end

   always_comb begin
      lk_hit = |match;
      lk_dom = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (match[i]) lk_dom = dom_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) en_q[i] <= 1'b0;
      end else if (wr_en) begin
         en_q[wr_slot] <= wr_enable;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         rid_q[wr_slot] <= wr_rid;
         dom_q[wr_slot] <= wr_dom;
      end
   end

   // R1: an enabled write is visible to a lookup of that identity one cycle later
   a_r1_prog_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_enable) |=> ((lk_rid != $past(wr_rid)) || lk_hit));
endmodule

// File: rtl/dmar_tlb.sv
module dmar_tlb #(
   parameter int ENTRIES     = 16,
   parameter int DOM_W       = 8,
   parameter int VPN_W       = 36,
   parameter int PPN_W       = 36,
   parameter int FILL_POLICY = 0,
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DOM_W-1:0] lk_dom,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             lk_rd,
   output logic             lk_wr,
   input  logic             fill_en,
   input  logic [DOM_W-1:0] fill_dom,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_rd,
   input  logic             fill_wr,
   input  logic             inv_en,
   input  logic [DOM_W-1:0] inv_dom
);
   logic               val_q [ENTRIES];
   logic [DOM_W-1:0]   dom_q [ENTRIES];
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   logic               rd_q  [ENTRIES];
   logic               wr_q  [ENTRIES];
   logic [ENTRIES-1:0] hit_vec;
   logic [IDX_W-1:0]   rr_ptr;
   logic [IDX_W-1:0]   victim;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("dmar_tlb: ENTRIES must be a power of two, at least 2");
   end
   if (FILL_POLICY != 0 && FILL_POLICY != 1) begin : g_bad_policy
      $error("dmar_tlb: FILL_POLICY must be 0 or 1");
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_vec[i] = val_q[i] && (dom_q[i] == lk_dom) && (vpn_q[i] == lk_vpn);
   end

   always_comb begin
      lk_hit = |hit_vec;
      lk_ppn = '0;
      lk_rd  = 1'b0;
      lk_wr  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_ppn = lk_ppn | ppn_q[i];
            lk_rd  = lk_rd | rd_q[i];
            lk_wr  = lk_wr | wr_q[i];
         end
      end
   end

   if (FILL_POLICY == 0) begin : g_rr
      assign victim = rr_ptr;
   end else begin : g_free_first
      always_comb begin
         victim = rr_ptr;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!val_q[i]) victim = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_ptr <= '0;
         for (int i = 0; i < ENTRIES; i++) val_q[i] <= 1'b0;
      end else begin
         if (inv_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (dom_q[i] == inv_dom) val_q[i] <= 1'b0;
            end
         end
         if (fill_en) begin
            val_q[victim] <= 1'b1;
            rr_ptr        <= victim + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         dom_q[victim] <= fill_dom;
         vpn_q[victim] <= fill_vpn;
         ppn_q[victim] <= fill_ppn;
         rd_q[victim]  <= fill_rd;
         wr_q[victim]  <= fill_wr;
      end
   end

   // R8: fills happen only on misses, so a tag is held at most once
   a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R9: after an invalidate, the named domain no longer hits
   a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && !fill_en) |=> !(lk_hit && (lk_dom == $past(inv_dom))));
endmodule

// File: rtl/dmar_unit.sv
module dmar_unit
   import dmar_pkg::*;
#(
   parameter int GPA_W       = 48,
   parameter int HPA_W       = 48,
   parameter int PAGE_SHIFT  = 12,
   parameter int DOM_W       = 8,
   parameter int CTX_SLOTS   = 8,
   parameter int TLB_ENTRIES = 16,
   parameter int FILL_POLICY = 0,
   localparam int VPN_W  = GPA_W - PAGE_SHIFT,
   localparam int PPN_W  = HPA_W - PAGE_SHIFT,
   localparam int SLOT_W = (CTX_SLOTS > 1) ? $clog2(CTX_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [15:0]       req_rid,
   input  logic              req_write,
   input  logic [GPA_W-1:0]  req_gpa,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [HPA_W-1:0]  rsp_hpa,
   input  logic              ctx_wr,
   input  logic [SLOT_W-1:0] ctx_slot,
   input  logic [15:0]       ctx_rid,
   input  logic [DOM_W-1:0]  ctx_dom,
   input  logic              ctx_enable,
   output logic              miss_valid,
   output logic [DOM_W-1:0]  miss_dom,
   output logic [VPN_W-1:0]  miss_vpn,
   input  logic              fill_valid,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic              fill_read,
   input  logic              fill_write,
   input  logic              inv_valid,
   input  logic [DOM_W-1:0]  inv_dom,
   output logic              fault_valid,
   output logic [1:0]        fault_code,
   output logic [15:0]       fault_rid,
   output logic [GPA_W-1:0]  fault_gpa
);
   if (PAGE_SHIFT < 1 || GPA_W <= PAGE_SHIFT || HPA_W <= PAGE_SHIFT) begin : g_bad_widths
      $error("dmar_unit: address widths must exceed PAGE_SHIFT");
   end
   if (RID_W != 16) begin : g_bad_rid
      $error("dmar_unit: requester identity must be 16 bits");
   end

   dmar_state_e       state;
   logic [15:0]       q_rid;
   logic              q_write;
   logic [GPA_W-1:0]  q_gpa;
   logic [DOM_W-1:0]  q_dom;
   logic              ctx_hit;
   logic [DOM_W-1:0]  ctx_lk_dom;
   logic              tlb_hit;
   logic [PPN_W-1:0]  tlb_ppn;
   logic              tlb_rd;
   logic              tlb_wr;
   logic              fill_en;
   logic              perm_ok;

   assign req_ready  = (state == ST_IDLE);
   assign miss_valid = (state == ST_WAIT);
   assign miss_dom   = q_dom;
   assign miss_vpn   = q_gpa[GPA_W-1:PAGE_SHIFT];
   assign fill_en    = (state == ST_WAIT) && fill_valid;
   assign perm_ok    = q_write ? tlb_wr : tlb_rd;

   dmar_ctx_table #(
      .SLOTS (CTX_SLOTS),
      .RID_W (RID_W),
      .DOM_W (DOM_W)
   ) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctx_wr),
      .wr_slot   (ctx_slot),
      .wr_rid    (ctx_rid),
      .wr_dom    (ctx_dom),
      .wr_enable (ctx_enable),
      .lk_rid    (q_rid),
      .lk_hit    (ctx_hit),
      .lk_dom    (ctx_lk_dom)
   );

   dmar_tlb #(
      .ENTRIES     (TLB_ENTRIES),
      .DOM_W       (DOM_W),
      .VPN_W       (VPN_W),
      .PPN_W       (PPN_W),
      .FILL_POLICY (FILL_POLICY)
   ) u_tlb (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_dom   (ctx_lk_dom),
      .lk_vpn   (q_gpa[GPA_W-1:PAGE_SHIFT]),
      .lk_hit   (tlb_hit),
      .lk_ppn   (tlb_ppn),
      .lk_rd    (tlb_rd),
      .lk_wr    (tlb_wr),
      .fill_en  (fill_en),
      .fill_dom (q_dom),
      .fill_vpn (q_gpa[GPA_W-1:PAGE_SHIFT]),
      .fill_ppn (fill_ppn),
      .fill_rd  (fill_read),
      .fill_wr  (fill_write),
      .inv_en   (inv_valid),
      .inv_dom  (inv_dom)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         q_rid       <= '0;
         q_write     <= 1'b0;
         q_gpa       <= '0;
         q_dom       <= '0;
         rsp_valid   <= 1'b0;
         rsp_fault   <= 1'b0;
         rsp_hpa     <= '0;
         fault_valid <= 1'b0;
         fault_code  <= FLT_NONE;
         fault_rid   <= '0;
         fault_gpa   <= '0;
      end else begin
         rsp_valid   <= 1'b0;
         fault_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  q_rid   <= req_rid;
                  q_write <= req_write;
                  q_gpa   <= req_gpa;
                  state   <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (!ctx_hit || (tlb_hit && !perm_ok)) begin
                  rsp_valid   <= 1'b1;
                  rsp_fault   <= 1'b1;
                  rsp_hpa     <= '0;
                  fault_valid <= 1'b1;
                  fault_code  <= ctx_hit ? FLT_PERM : FLT_NOCTX;
                  fault_rid   <= q_rid;
                  fault_gpa   <= q_gpa;
                  state       <= ST_IDLE;
               end else if (tlb_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_hpa   <= {tlb_ppn, q_gpa[PAGE_SHIFT-1:0]};
                  state     <= ST_IDLE;
               end else begin
                  q_dom <= ctx_lk_dom;
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (fill_valid) state <= ST_LOOK;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7: an accepted request closes the port for the next cycle
   a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !rsp_valid));
   // R4: a pending miss holds with stable contents until filled
   a_r4_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && !fill_valid) |=> (miss_valid && $stable(miss_vpn) && $stable(miss_dom)));
   // R5: a fill produces a response two edges later
   a_r5_fill_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && fill_valid) |-> ##2 rsp_valid);
   // R2: a missing context never leads to a software request
   a_r2_noctx_nomiss: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && fault_code == FLT_NOCTX) |-> (rsp_fault && !miss_valid));
   // R6: fault record and faulting response appear together
   a_r6_fault_pair: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == fault_valid));
   // R3: a response is a single-cycle pulse
   a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: tb/tb_dmar_unit.sv
module tb_dmar_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [15:0] rid;
      logic        wr;
      logic [47:0] gpa;
      logic        miss;
      logic [35:0] ppn;
      logic        fr;
      logic        fw;
      logic [1:0]  code;
      logic [7:0]  dom;
   } vec_t;

   localparam vec_t VEC [0:7] = '{
      '{16'h0108, 1'b0, 48'h0000_1234_5678, 1'b1, 36'h0_0000_AAAA, 1'b1, 1'b1, 2'd0, 8'd3},
      '{16'h0108, 1'b1, 48'h0000_1234_5FFF, 1'b0, 36'h0_0000_AAAA, 1'b1, 1'b1, 2'd0, 8'd3},
      '{16'h0109, 1'b0, 48'h0000_1234_5010, 1'b0, 36'h0_0000_AAAA, 1'b1, 1'b1, 2'd0, 8'd3},
      '{16'h0211, 1'b0, 48'h0000_1234_5020, 1'b1, 36'h0_0000_BBBB, 1'b1, 1'b0, 2'd0, 8'd5},
      '{16'h0211, 1'b1, 48'h0000_1234_5024, 1'b0, 36'h0_0000_BBBB, 1'b1, 1'b0, 2'd2, 8'd5},
      '{16'h0300, 1'b0, 48'h0000_0000_4000, 1'b0, 36'h0,           1'b0, 1'b0, 2'd1, 8'd0},
      '{16'h0211, 1'b0, 48'h0000_0007_7008, 1'b1, 36'h0_0000_CCCC, 1'b0, 1'b1, 2'd2, 8'd5},
      '{16'h0108, 1'b1, 48'hFFFF_FFFF_F123, 1'b1, 36'h0_0000_0001, 1'b1, 1'b1, 2'd0, 8'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_rid = '0;
   logic        req_write = 1'b0;
   logic [47:0] req_gpa = '0;
   logic        rsp_valid, rsp_fault;
   logic [47:0] rsp_hpa;
   logic        ctx_wr = 1'b0;
   logic [2:0]  ctx_slot = '0;
   logic [15:0] ctx_rid = '0;
   logic [7:0]  ctx_dom = '0;
   logic        ctx_enable = 1'b0;
   logic        miss_valid;
   logic [7:0]  miss_dom;
   logic [35:0] miss_vpn;
   logic        fill_valid = 1'b0;
   logic [35:0] fill_ppn = '0;
   logic        fill_read = 1'b0;
   logic        fill_write = 1'b0;
   logic        inv_valid = 1'b0;
   logic [7:0]  inv_dom = '0;
   logic        fault_valid;
   logic [1:0]  fault_code;
   logic [15:0] fault_rid;
   logic [47:0] fault_gpa;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dmar_unit dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_rid(req_rid),
      .req_write(req_write), .req_gpa(req_gpa),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_hpa(rsp_hpa),
      .ctx_wr(ctx_wr), .ctx_slot(ctx_slot), .ctx_rid(ctx_rid),
      .ctx_dom(ctx_dom), .ctx_enable(ctx_enable),
      .miss_valid(miss_valid), .miss_dom(miss_dom), .miss_vpn(miss_vpn),
      .fill_valid(fill_valid), .fill_ppn(fill_ppn),
      .fill_read(fill_read), .fill_write(fill_write),
      .inv_valid(inv_valid), .inv_dom(inv_dom),
      .fault_valid(fault_valid), .fault_code(fault_code),
      .fault_rid(fault_rid), .fault_gpa(fault_gpa)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic prog_ctx(input logic [2:0] slot, input logic [15:0] rid,
                           input logic [7:0] dom, input logic en);
      @(negedge clk);
      ctx_wr = 1'b1; ctx_slot = slot; ctx_rid = rid; ctx_dom = dom; ctx_enable = en;
      @(posedge clk);
      @(negedge clk);
      ctx_wr = 1'b0;
   endtask

   task automatic invalidate(input logic [7:0] dom);
      @(negedge clk);
      inv_valid = 1'b1; inv_dom = dom;
      @(posedge clk);
      @(negedge clk);
      inv_valid = 1'b0;
   endtask

   // One DMA from acceptance to response, sampled in the exact due cycles.
   task automatic do_req(input string tag, input vec_t v, input int stall);
      @(negedge clk);
      req_valid = 1'b1; req_rid = v.rid; req_write = v.wr; req_gpa = v.gpa;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7", "ready low in lookup", {63'b0, req_ready}, 64'd0);
      @(posedge clk);
      @(negedge clk);
      if (v.miss) begin
         chk("R4", "miss_valid", {63'b0, miss_valid}, 64'd1);
         chk("R4", "no early response", {63'b0, rsp_valid}, 64'd0);
         chk("R4", "miss_dom", {56'b0, miss_dom}, {56'b0, v.dom});
         chk("R4", "miss_vpn", {28'b0, miss_vpn}, {28'b0, v.gpa[47:12]});
         for (int s = 0; s < stall; s++) begin
            req_valid = 1'b1; req_rid = 16'h0300; req_gpa = 48'h9000;
            @(posedge clk);
            @(negedge clk);
            chk("R7", "ready low while stalled", {63'b0, req_ready}, 64'd0);
            chk("R4", "miss held while stalled", {63'b0, miss_valid}, 64'd1);
            chk("R4", "miss page stable", {28'b0, miss_vpn}, {28'b0, v.gpa[47:12]});
         end
         req_valid = 1'b0;
         fill_valid = 1'b1; fill_ppn = v.ppn; fill_read = v.fr; fill_write = v.fw;
         @(posedge clk);
         @(negedge clk);
         fill_valid = 1'b0;
         chk("R5", "no response in retry cycle", {63'b0, rsp_valid}, 64'd0);
         @(posedge clk);
         @(negedge clk);
      end
      chk(tag, "rsp_valid", {63'b0, rsp_valid}, 64'd1);
      chk(tag, "rsp_fault", {63'b0, rsp_fault}, {63'b0, (v.code != 2'd0)});
      chk(tag, "fault_valid", {63'b0, fault_valid}, {63'b0, (v.code != 2'd0)});
      chk("R2", "no miss on answer", {63'b0, miss_valid}, 64'd0);
      if (v.code == 2'd0) begin
         chk(tag, "rsp_hpa", {16'b0, rsp_hpa}, {16'b0, v.ppn, v.gpa[11:0]});
      end else begin
         chk(tag, "fault_code", {62'b0, fault_code}, {62'b0, v.code});
         chk(tag, "fault_rid", {48'b0, fault_rid}, {48'b0, v.rid});
         chk(tag, "fault_gpa", {16'b0, fault_gpa}, {16'b0, v.gpa});
      end
      @(posedge clk);
      @(negedge clk);
      chk("R3", "response is one cycle", {63'b0, rsp_valid}, 64'd0);
   endtask

   function automatic vec_t mk(input logic [15:0] rid, input logic wr,
                               input logic [47:0] gpa, input logic miss,
                               input logic [35:0] ppn, input logic [1:0] code,
                               input logic [7:0] dom);
      vec_t v;
      v.rid = rid; v.wr = wr; v.gpa = gpa; v.miss = miss; v.ppn = ppn;
      v.fr = 1'b1; v.fw = 1'b1; v.code = code; v.dom = dom;
      return v;
   endfunction

   initial begin : watchdog
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      string tag;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R7", "reset req_ready", {63'b0, req_ready}, 64'd1);
      chk("R3", "reset rsp_valid", {63'b0, rsp_valid}, 64'd0);
      chk("R4", "reset miss_valid", {63'b0, miss_valid}, 64'd0);
      chk("R2", "reset fault_valid", {63'b0, fault_valid}, 64'd0);

      // R1: bus 1 dev 1 fn 0 and fn 1 share domain 3; bus 2 dev 2 fn 1 uses domain 5
      prog_ctx(3'd0, 16'h0108, 8'd3, 1'b1);
      prog_ctx(3'd1, 16'h0211, 8'd5, 1'b1);
      prog_ctx(3'd2, 16'h0109, 8'd3, 1'b1);

      for (int i = 0; i < 8; i++) begin
         if (VEC[i].code == 2'd1) tag = "R2";
         else if (VEC[i].code == 2'd2) tag = "R6";
         else if (VEC[i].miss) tag = "R5";
         else if (VEC[i].rid == 16'h0109) tag = "R1";
         else tag = "R3";
         do_req(tag, VEC[i], 0);
      end

      // R9: drop domain 5; domain 3 still hits, domain 5 misses (refill with a stall, R7)
      invalidate(8'd5);
      do_req("R9", mk(16'h0108, 1'b0, 48'h0000_1234_5ABC, 1'b0, 36'hAAAA, 2'd0, 8'd3), 0);
      do_req("R9", mk(16'h0211, 1'b0, 48'h0000_1234_5020, 1'b1, 36'hDDDD, 2'd0, 8'd5), 4);

      // R8: 16 more fills wrap the round-robin pointer past the oldest entry
      for (int p = 0; p < 16; p++) begin
         do_req("R8", mk(16'h0108, 1'b0, {24'h0, 12'h100 + 12'(p), 12'h004}, 1'b1,
                         36'h500 + 36'(p), 2'd0, 8'd3), 0);
      end
      do_req("R8", mk(16'h0108, 1'b0, 48'h0000_0010_0FF0, 1'b0, 36'h500, 2'd0, 8'd3), 0);
      do_req("R8", mk(16'h0108, 1'b1, 48'h0000_0010_F000, 1'b0, 36'h50F, 2'd0, 8'd3), 0);
      do_req("R8", mk(16'h0108, 1'b0, 48'h0000_1234_5000, 1'b1, 36'hEEEE, 2'd0, 8'd3), 0);

      // R1 and R2: disabling a slot makes its requester fault despite cached pages
      prog_ctx(3'd2, 16'h0109, 8'd3, 1'b0);
      do_req("R2", mk(16'h0109, 1'b0, 48'h0000_1234_5040, 1'b0, 36'h0, 2'd1, 8'd3), 0);
      do_req("R1", mk(16'h0108, 1'b0, 48'h0000_1234_5040, 1'b0, 36'hEEEE, 2'd0, 8'd3), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule